// File: doc/BRIEF.md
# Element-Wise Array Summing Engine

This block holds two source tables of eight 4-bit values and a result table of the same shape. After a start request, it walks an index over all eight rows. For each row it fetches the two source values, adds them and stores the 4-bit sum in the matching row of the result table. All three tables are single-ported synchronous memories, so a value read at one clock edge is only available in the next cycle. The result write therefore runs one stage behind the read, and it uses a registered copy of the index.

While the block is idle, software-side logic fills the source tables through a shared load port. A select line picks the target table. A debug port reads the result table back. A run keeps the busy flag high for nine cycles: eight read cycles plus one trailing write. A one-cycle done pulse follows the run.

Top module: `arr_sum_engine`

## Requirements
- R1: After reset, busy_o and done_o are both 0.
- R2: While busy_o is 0, a cycle with load_en_i=1 writes load_data_i into row load_addr_i of table A when load_sel_i=0, or of table B when load_sel_i=1, at that clock edge.
- R3: A start_i sampled high while busy_o is 0 makes busy_o go high on the next cycle. busy_o then stays high for exactly 9 consecutive cycles.
- R4: done_o is high for exactly one cycle: the first cycle after a run in which busy_o is low again.
- R5: After a run, result row i holds (A[i] + B[i]) mod 16 for every i from 0 to 7.
- R6: The carry out of the 4-bit sum is dropped. For example, 9+9 stores 2 and 15+15 stores 14.
- R7: A start_i pulse while busy_o is 1 is ignored. The run still lasts 9 cycles and produces a single done pulse.
- R8: While busy_o is 0, dbg_data_o shows result row dbg_addr_i one cycle after that address is sampled.
- R9: Load requests made while busy_o is 1 are dropped and leave tables A and B unchanged.
- R10: Reset clears the sequencing state but keeps the contents of all three tables.
- R11: The result row written in each cycle is the index that was read in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to begin a run |
| load_en_i | input | 1 | Write one source row |
| load_sel_i | input | 1 | Target table: 0 for A, 1 for B |
| load_addr_i | input | 3 | Row to load |
| load_data_i | input | 4 | Value to load |
| dbg_addr_i | input | 3 | Result row to read back |
| dbg_data_o | output | 4 | Result row contents, one cycle after the address |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench drives start_i in one cycle and expects busy_o high in the cycle after the sampling edge. It counts nine busy cycles and then expects done_o in the tenth cycle, which is the first cycle with busy_o low. It requires done_o to be gone one cycle after that. Each debug read is issued at the falling edge. A monitor records the sampling rising edge and compares dbg_data_o at the following falling edge with the value the driver queued, so every read is checked one cycle after its address. Loads land at the edge after they are driven, and a run is started only after the last load has landed.

// File: rtl/arr_sum_pkg.sv
package arr_sum_pkg;
  localparam int unsigned ROW_AW = 3;
  localparam int unsigned VAL_W  = 4;
  typedef logic [ROW_AW-1:0] row_t;
  typedef logic [VAL_W-1:0]  val_t;
endpackage

// File: rtl/arr_mem.sv
module arr_mem #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          en,
  input  logic          wen,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] rows [DEPTH];

  always_ff @(posedge clk) begin
    if (en && wen) begin
      rows[addr] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (en && !wen) begin
      dout <= rows[addr];
    end
  end
endmodule

// File: rtl/idx_counter.sv
module idx_counter #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr) begin
      q_d = '0;
    end else if (en) begin
      q_d = q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(clr)) |-> (q == W'($past(q) + 1'b1))) else $error("idx step"); // R3
endmodule

// File: rtl/pipe_reg.sv
module pipe_reg #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end
endmodule

// File: rtl/add_ripple.sv
module add_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  logic [W-1:0] c;

  assign c[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i] = a[i] ^ b[i] ^ c[i];
    if (i < W - 1) begin : g_carry
      assign c[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
    end
  end
endmodule

// File: rtl/arr_sum_engine.sv
module arr_sum_engine
  import arr_sum_pkg::*;
#(
  parameter int unsigned AW = ROW_AW,
  parameter int unsigned DW = VAL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          load_en_i,
  input  logic          load_sel_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic [DW-1:0] load_data_i,
  input  logic [AW-1:0] dbg_addr_i,
  output logic [DW-1:0] dbg_data_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST_ROW = AW'((1 << AW) - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync[1];

  // sequencing state
  logic          rd_active, rd_active_d;
  logic          wr_pend, wr_pend_d;
  logic          done_q, done_d;
  logic          start_ok;
  logic [AW-1:0] idx, wr_idx;

  assign busy_o   = rd_active | wr_pend;
  assign done_o   = done_q;
  assign start_ok = start_i & ~busy_o;

  always_comb begin
    rd_active_d = rd_active;
    if (start_ok) begin
      rd_active_d = 1'b1;
    end else if (rd_active && (idx == LAST_ROW)) begin
      rd_active_d = 1'b0;
    end
    wr_pend_d = rd_active;
    done_d    = wr_pend & (wr_idx == LAST_ROW);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rd_active <= 1'b0;
      wr_pend   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      rd_active <= rd_active_d;
      wr_pend   <= wr_pend_d;
      done_q    <= done_d;
    end
  end

  idx_counter #(.W(AW)) u_idx (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr   (start_ok),
    .en    (rd_active),
    .q     (idx)
  );

  pipe_reg #(.W(AW)) u_wr_idx (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en    (rd_active),
    .d     (idx),
    .q     (wr_idx)
  );

  // source tables: loaded while idle, read by the index while running
  logic          wen_a, wen_b, en_a, en_b;
  logic [AW-1:0] addr_ab;
  logic [DW-1:0] dout_a, dout_b, sum;

  always_comb begin
    wen_a   = ~busy_o & load_en_i & ~load_sel_i;
    wen_b   = ~busy_o & load_en_i &  load_sel_i;
    en_a    = rd_active | wen_a;
    en_b    = rd_active | wen_b;
    addr_ab = rd_active ? idx : load_addr_i;
  end

  arr_mem #(.AW(AW), .DW(DW)) u_mem_a (
    .clk (clk), .en (en_a), .wen (wen_a), .addr (addr_ab),
    .din (load_data_i), .dout (dout_a)
  );

  arr_mem #(.AW(AW), .DW(DW)) u_mem_b (
    .clk (clk), .en (en_b), .wen (wen_b), .addr (addr_ab),
    .din (load_data_i), .dout (dout_b)
  );

  add_ripple #(.W(DW)) u_add (
    .a (dout_a),
    .b (dout_b),
    .s (sum)
  );

  // result table: written one stage behind the read, debug read when idle
  logic          en_c;
  logic [AW-1:0] addr_c;

  always_comb begin
    en_c   = wr_pend | ~busy_o;
    addr_c = wr_pend ? wr_idx : dbg_addr_i;
  end

  arr_mem #(.AW(AW), .DW(DW)) u_mem_c (
    .clk (clk), .en (en_c), .wen (wr_pend), .addr (addr_c),
    .din (sum), .dout (dbg_data_o)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R4
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |-> (!busy_o && $past(busy_o))) else $error("done misplaced"); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_active && $past(rd_active)) |-> (idx != '0)) else $error("index restarted"); // R7
  AST_WR_ADDR_DELAY: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_pend |-> (wr_idx == $past(idx))) else $error("write row not delayed index"); // R11
endmodule

// File: tb/arr_sum_engine_test.sv
`timescale 1ns/1ps
module arr_sum_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       load_en_i = 1'b0;
  logic       load_sel_i = 1'b0;
  logic [2:0] load_addr_i = '0;
  logic [3:0] load_data_i = '0;
  logic [2:0] dbg_addr_i = '0;
  logic [3:0] dbg_data_o;
  logic       busy_o, done_o;

  int tests = 0;
  int fails = 0;
  logic [3:0] ma [8];
  logic [3:0] mb [8];

  logic [3:0] exp_q [$];
  string      msg_q [$];
  logic       dbg_issue = 1'b0;
  logic       dbg_pend = 1'b0;

  always #2 clk = ~clk;

  arr_sum_engine uut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i),
    .load_en_i (load_en_i), .load_sel_i (load_sel_i),
    .load_addr_i (load_addr_i), .load_data_i (load_data_i),
    .dbg_addr_i (dbg_addr_i), .dbg_data_o (dbg_data_o),
    .busy_o (busy_o), .done_o (done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: the address issued at one falling edge is sampled at the next
  // rising edge, and the result is compared at the falling edge after that
  always @(posedge clk) dbg_pend <= dbg_issue;

  always @(negedge clk) begin
    if (dbg_pend && exp_q.size() > 0) begin
      logic [3:0] e;
      string m;
      e = exp_q.pop_front();
      m = msg_q.pop_front();
      check(m, dbg_data_o, e);
    end
  end

  task automatic load_row(input logic sel, input int a, input logic [3:0] v);
    load_en_i = 1'b1; load_sel_i = sel; load_addr_i = 3'(a); load_data_i = v;
    @(negedge clk);
    load_en_i = 1'b0;
    if (sel) mb[a] = v; else ma[a] = v;   // R2 model
  endtask

  // driver: issue reads of all result rows and queue the expected values
  task automatic read_all(input string tag);
    for (int i = 0; i < 8; i++) begin
      dbg_addr_i = 3'(i);
      dbg_issue  = 1'b1;
      exp_q.push_back(4'((ma[i] + mb[i]) & 4'hF));
      msg_q.push_back($sformatf("%s row %0d", tag, i));
      @(negedge clk);
    end
    dbg_issue = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input bit poke_start, input bit poke_load);
    int cnt;
    int dones;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R3 busy after start", busy_o, 1);
    cnt = 0;
    dones = 0;
    while (busy_o && cnt < 20) begin
      cnt++;
      start_i   = (poke_start && cnt == 3);
      load_en_i = (poke_load && cnt == 4);
      load_sel_i = 1'b0; load_addr_i = 3'd3; load_data_i = 4'hF;  // R9 dropped
      if (done_o) dones++;
      @(negedge clk);
    end
    start_i = 1'b0;
    load_en_i = 1'b0;
    check("R3 busy length", cnt, 9);
    check("R4 done after run", done_o, 1);
    if (poke_start) check("R7 no early done", dones, 0);
    @(negedge clk);
    check("R4 done one cycle", done_o, 0);
    if (poke_start) check("R7 no restart", busy_o, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R3 actual=hang expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy after reset", busy_o, 0);
    check("R1 done after reset", done_o, 0);

    // first pattern with carries: R2, R5, R6
    begin
      logic [3:0] av [8] = '{4'd9, 4'd15, 4'd3, 4'd0, 4'd8, 4'd7, 4'd1, 4'd12};
      logic [3:0] bv [8] = '{4'd9, 4'd15, 4'd4, 4'd0, 4'd8, 4'd2, 4'd14, 4'd3};
      for (int i = 0; i < 8; i++) begin
        load_row(1'b0, i, av[i]);
        load_row(1'b1, i, bv[i]);
      end
    end
    run(1'b0, 1'b0);
    read_all("R5/R6/R8/R11 run1");

    // second pattern, start poked during the run: R7
    for (int i = 0; i < 8; i++) load_row(1'b1, i, 4'(i));
    run(1'b1, 1'b0);
    read_all("R5/R7/R11 run2");

    // load attempted during run is dropped: R9
    for (int i = 0; i < 8; i++) load_row(1'b0, i, 4'(7 - i));
    run(1'b0, 1'b1);
    run(1'b0, 1'b0);
    read_all("R9 run4");

    // reset keeps table contents: R10
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 idle after reset", busy_o, 0);
    read_all("R10 after reset");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule